// File: doc/BRIEF.md
# Reference clock frequency estimator

This block works out which standard band an unknown bus reference clock falls in. It starts from a 9-bit ratio count that relates the reference to a PLL of known base frequency: count = F_ref * 192 / F_pll. A `start` pulse begins an estimate. If the saved word offered at that moment carries a valid signature, the block takes the count from that word and skips averaging. Otherwise it collects 128 live counter samples over a valid/ready stream and averages them.

The averaged count is then turned into a frequency in MHz by integer arithmetic. The frequency is snapped to one of four bands and encoded as a clock index. A one-cycle `done` pulse marks the result.

The sample stream follows valid/ready rules. The block asserts `s_ready` only while it is collecting. A sample transfers on a rising edge where both `s_valid` and `s_ready` are high. The producer may hold `s_valid` high for any length of time; anything offered while `s_ready` is low is neither taken nor counted. `pll_mhz` must stay constant from `start` until `done`. `saved_word` is looked at only in the cycle where `start` is high.

Top module: `refclk_estimator`

## Requirements
- R1: After reset, `avg_count` is 0, `band_idx` is 1 (the 33 MHz code), and both `done` and `s_ready` are low.
- R2: If `saved_word[31:12]` equals 20'hABCDE when `start` is sampled, `avg_count` becomes `saved_word[8:0]` and bits 11:9 have no effect. In this case `done` is high during the second cycle after the start edge: the start edge is the first edge, and `done` rises at the edge after it.
- R3: Without a valid signature, `s_ready` stays high until exactly 128 samples have transferred. Samples offered while `s_ready` is low are ignored and do not enter the average.
- R4: On the collection path, `avg_count` equals the sum of the 128 transferred samples divided by 128, rounded down.
- R5: The estimate is floor(avg_count * pll_mhz / 192). Below 40 it snaps to 33 MHz, below 45 to 40 MHz, below 55 to 50 MHz, and otherwise to 66 MHz. The codes for `band_idx` are 0 = 25, 1 = 33, 2 = 40, 3 = 50 and 4 = 66 MHz; only codes 1 to 4 can be produced.
- R6: `done` is high for exactly one cycle. It rises at the edge after the edge on which the 128th sample transfers. `s_ready` is low while `done` is high.
- R7: `avg_count` and `band_idx` change only at the edge that raises `done`, and hold their values between results.
- R8: A `start` pulse in any state abandons the estimate in progress. It clears the running sum and the sample count, and the abandoned run produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a new estimate |
| saved_word | input | 32 | Saved value: signature in the upper 20 bits, count in the low 9 bits |
| pll_mhz | input | 8 | PLL base frequency in MHz |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready; high only while collecting |
| s_count | input | 9 | Live ratio counter sample |
| avg_count | output | 9 | Count used for the last result |
| band_idx | output | 3 | Clock index of the snapped band |
| done | output | 1 | One-cycle result pulse |

## Verification
Some properties are checked by the assertions on every cycle. `done` is a single-cycle pulse and never coincides with `s_ready`. The produced band code always lies between 1 and 4. The outputs hold between results. A signed start reaches `done` after one cycle. A `start` suppresses the next `done`. A collection result always follows exactly 128 transfers. The arithmetic needs the bench's scenarios: averaging random sample sets, the exact band edges at 40, 45 and 55 MHz, signature near-misses that must fall back to collection, samples offered outside collection, and a restart in the middle of a collection.

// File: rtl/refest_pkg.sv
package refest_pkg;

  typedef enum logic [2:0] {
    IDX_25 = 3'd0,
    IDX_33 = 3'd1,
    IDX_40 = 3'd2,
    IDX_50 = 3'd3,
    IDX_66 = 3'd4
  } clk_idx_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_CONV
  } est_state_e;

  // band edges in MHz, lower edge inclusive for the upper band
  localparam int unsigned EDGE_LO  = 40;
  localparam int unsigned EDGE_MID = 45;
  localparam int unsigned EDGE_HI  = 55;

  function automatic logic [6:0] snap_mhz(input int unsigned est);
    if (est < EDGE_LO)       return 7'd33;
    else if (est < EDGE_MID) return 7'd40;
    else if (est < EDGE_HI)  return 7'd50;
    else                     return 7'd66;
  endfunction

  function automatic clk_idx_e mhz_to_idx(input logic [6:0] mhz);
    case (mhz)
      7'd25:   return IDX_25;
      7'd33:   return IDX_33;
      7'd40:   return IDX_40;
      7'd50:   return IDX_50;
      7'd66:   return IDX_66;
      default: return IDX_33;
    endcase
  endfunction

endpackage

// File: rtl/refest_accum.sv
module refest_accum
  import refest_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int ACC_W = 16,
  parameter int NSAMP = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic [CNT_W-1:0] sample,
  output logic             last_take,
  output logic [CNT_W-1:0] mean
);

  localparam int SHIFT = $clog2(NSAMP);
  localparam int SC_W  = (SHIFT < 1) ? 1 : SHIFT;

  logic [ACC_W-1:0] sum_q;
  logic [SC_W-1:0]  n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      n_q   <= '0;
    end else if (clear) begin
      sum_q <= '0;
      n_q   <= '0;
    end else if (take) begin
      sum_q <= sum_q + ACC_W'(sample);
      n_q   <= n_q + 1'b1;
    end
  end

  assign last_take = take && (n_q == SC_W'(NSAMP - 1));
  assign mean      = CNT_W'(sum_q >> SHIFT);

endmodule

// File: rtl/refest_band.sv
module refest_band
  import refest_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int PLL_W = 8,
  parameter int RATIO = 192
) (
  input  logic [CNT_W-1:0] count,
  input  logic [PLL_W-1:0] pll_mhz,
  output clk_idx_e         idx
);

  localparam int PROD_W = CNT_W + PLL_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] est;
  logic [6:0]        band;

  always_comb begin
    prod = PROD_W'(count) * PROD_W'(pll_mhz);
    est  = prod / PROD_W'(RATIO);
    band = snap_mhz(32'(est));
    idx  = mhz_to_idx(band);
  end

endmodule

// File: rtl/refclk_estimator.sv
module refclk_estimator
  import refest_pkg::*;
#(
  parameter int          CNT_W   = 9,
  parameter int          ACC_W   = 16,
  parameter int          NSAMP   = 128,
  parameter int          PLL_W   = 8,
  parameter int          RATIO   = 192,
  parameter int          SIG_W   = 20,
  parameter logic [19:0] SIG_VAL = 20'hABCDE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      saved_word,
  input  logic [PLL_W-1:0] pll_mhz,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [CNT_W-1:0] s_count,
  output logic [CNT_W-1:0] avg_count,
  output logic [2:0]       band_idx,
  output logic             done
);

  est_state_e       st_q;
  logic             use_saved_q;
  logic [CNT_W-1:0] saved_cnt_q;
  logic             sig_ok;
  logic             take;
  logic             last_take;
  logic [CNT_W-1:0] mean;
  logic [CNT_W-1:0] cnt_sel;
  clk_idx_e         idx_c;
  clk_idx_e         idx_q;

  assign sig_ok  = (saved_word[31 -: SIG_W] == SIG_VAL[SIG_W-1:0]);
  assign s_ready = (st_q == ST_COLLECT);
  assign take    = s_valid && s_ready;
  assign cnt_sel = use_saved_q ? saved_cnt_q : mean;

  refest_accum #(
    .CNT_W (CNT_W),
    .ACC_W (ACC_W),
    .NSAMP (NSAMP)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .take      (take),
    .sample    (s_count),
    .last_take (last_take),
    .mean      (mean)
  );

  refest_band #(
    .CNT_W (CNT_W),
    .PLL_W (PLL_W),
    .RATIO (RATIO)
  ) u_band (
    .count   (cnt_sel),
    .pll_mhz (pll_mhz),
    .idx     (idx_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      use_saved_q <= 1'b0;
      saved_cnt_q <= '0;
      avg_count   <= '0;
      idx_q       <= IDX_33;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        use_saved_q <= sig_ok;
        if (sig_ok) begin
          saved_cnt_q <= saved_word[CNT_W-1:0];
          st_q        <= ST_CONV;
        end else begin
          st_q <= ST_COLLECT;
        end
      end else begin
        case (st_q)
          ST_COLLECT: if (last_take) st_q <= ST_CONV;
          ST_CONV: begin
            avg_count <= cnt_sel;
            idx_q     <= idx_c;
            done      <= 1'b1;
            st_q      <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign band_idx = idx_q;

endmodule

// File: rtl/refest_checker.sv
module refest_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] saved_word,
  input logic        s_valid,
  input logic        s_ready,
  input logic [8:0]  avg_count,
  input logic [2:0]  band_idx,
  input logic        done
);

  logic [7:0] xfers;
  logic       fast;
  logic       past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfers   <= '0;
      fast    <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (start) begin
        xfers <= '0;
        fast  <= (saved_word[31:12] == 20'hABCDE);
      end else if (s_valid && s_ready) begin
        xfers <= xfers + 8'd1;
      end
    end
  end

  // R2: signed start reaches done one cycle later
  assert_fast_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && saved_word[31:12] == 20'hABCDE) ##1 !start |=> done);

  assert_ready_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (xfers < 8'd128));

  assert_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fast || xfers == 8'd128));

  assert_band_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (band_idx >= 3'd1) && (band_idx <= 3'd4));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !s_ready);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !done) |-> ($stable(avg_count) && $stable(band_idx)));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

endmodule

bind refclk_estimator refest_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .saved_word (saved_word),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .avg_count  (avg_count),
  .band_idx   (band_idx),
  .done       (done)
);

// File: tb/tb_refclk_estimator.sv
`timescale 1ns/1ps
module tb_refclk_estimator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] saved_word = '0;
  logic [7:0]  pll_mhz = 8'd48;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [8:0]  s_count = '0;
  logic [8:0]  avg_count;
  logic [2:0]  band_idx;
  logic        done;

  int checks = 0;
  int errors = 0;
  int samp[128];

  always #5 clk = ~clk;

  refclk_estimator dut (
    .clk(clk), .rst_n(rst_n), .start(start), .saved_word(saved_word),
    .pll_mhz(pll_mhz), .s_valid(s_valid), .s_ready(s_ready), .s_count(s_count),
    .avg_count(avg_count), .band_idx(band_idx), .done(done)
  );

  function automatic int exp_idx(int cnt, int pll);
    int f;
    f = (cnt * pll) / 192;
    if (f < 40) return 1;
    if (f < 45) return 2;
    if (f < 55) return 3;
    return 4;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(logic [31:0] w);
    @(negedge clk);
    saved_word = w;
    s_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits at negedges for done, returns the number of negedges taken
  task automatic wait_done(output int lat);
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      if (k > 0 || 1) begin
        lat++;
        if (done) break;
        @(negedge clk);
        s_valid = 1'b0;
      end
    end
    if (!done) begin
      errors++;
      $display("FAIL R6 actual=no_done expected=done");
    end
  endtask

  task automatic run_fast(int cnt, int pll, logic [2:0] junk);
    int lat;
    pll_mhz = 8'(pll);
    pulse_start({20'hABCDE, junk, 9'(cnt)});
    @(negedge clk);
    wait_done(lat);
    chk("R2 latency", lat, 1);
    chk("R2 avg", int'(avg_count), cnt);
    chk("R5 band", int'(band_idx), exp_idx(cnt, pll));
  endtask

  task automatic feed(int n, bit fixed, int fval);
    int i;
    bit v, rdy;
    i = 0;
    while (i < n) begin
      @(negedge clk);
      rdy = s_ready;
      v = ($urandom % 4) != 0;
      s_valid = v;
      s_count = fixed ? 9'(fval) : 9'(samp[i]);
      @(posedge clk);
      if (rdy && v) i++;
    end
  endtask

  task automatic run_slow(int pll, logic [31:0] w, string tag);
    int sum, lat, expv;
    sum = 0;
    for (int j = 0; j < 128; j++) sum += samp[j];
    expv = sum / 128;
    pll_mhz = 8'(pll);
    pulse_start(w);
    chk("R3 ready", int'(s_ready), 1);
    feed(128, 1'b0, 0);
    @(negedge clk);
    s_valid = 1'b0;
    chk("R6 not yet", int'(done), 0);
    @(negedge clk);
    wait_done(lat);
    chk("R6 latency", lat, 1);
    chk({tag, " avg"}, int'(avg_count), expv);
    chk("R5 band", int'(band_idx), exp_idx(expv, pll));
    chk("R6 ready low", int'(s_ready), 0);
    @(negedge clk);
    chk("R6 pulse", int'(done), 0);
  endtask

  initial begin
    process::self().srandom(32'd1234);
  end

  initial begin
    int pl[5];
    logic [8:0] keep_a;
    logic [2:0] keep_b;
    pl = '{48, 50, 55, 66, 77};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 avg", int'(avg_count), 0);
    chk("R1 band", int'(band_idx), 1);
    chk("R1 done", int'(done), 0);
    chk("R1 ready", int'(s_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R5 band edges with pll 48 (estimate = count/4)
    run_fast(159, 48, 3'b111);
    run_fast(160, 48, 3'b101);
    run_fast(179, 48, 3'b010);
    run_fast(180, 48, 3'b000);
    run_fast(219, 48, 3'b111);
    run_fast(220, 48, 3'b011);
    run_fast(0, 48, 3'b000);
    run_fast(511, 77, 3'b111);

    // R3 near-miss signature falls back to collection; junk offered while idle
    @(negedge clk);
    s_valid = 1'b1; s_count = 9'd511;
    repeat (4) @(negedge clk);
    for (int j = 0; j < 128; j++) samp[j] = 300;
    run_slow(66, 32'hABCDF0A0, "R3");

    // R4 random sample sets
    for (int r = 0; r < 5; r++) begin
      for (int j = 0; j < 128; j++) samp[j] = $urandom % 512;
      run_slow(pl[r], $urandom & 32'hFFFF_0FFF, "R4");
    end
    // R4 extremes
    for (int j = 0; j < 128; j++) samp[j] = 511;
    run_slow(48, 32'h0, "R4");

    // R7 outputs hold while inputs move
    keep_a = avg_count; keep_b = band_idx;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_count = 9'($urandom); pll_mhz = 8'($urandom);
      saved_word = $urandom;
    end
    @(negedge clk);
    s_valid = 1'b0;
    chk("R7 avg hold", int'(avg_count), int'(keep_a));
    chk("R7 band hold", int'(band_idx), int'(keep_b));

    // R8 restart mid-collection
    pll_mhz = 8'd48;
    pulse_start(32'h1234_5678);
    feed(50, 1'b1, 511);
    @(negedge clk);
    s_valid = 1'b0;
    for (int j = 0; j < 128; j++) samp[j] = 100 + (j % 8);
    run_slow(48, 32'h0, "R8");

    // R8 start during conversion suppresses done
    pulse_start({20'hABCDE, 12'd200});
    start = 1'b1;
    saved_word = {20'hABCDE, 12'd20};
    @(negedge clk);
    start = 1'b0;
    chk("R8 no done", int'(done), 0);
    @(negedge clk);
    chk("R8 new done", int'(done), 1);
    chk("R8 avg", int'(avg_count), 20);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule